// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-facing side of a simple serial port. A processor reaches it over a 32-bit register bus with a request/acknowledge handshake. Received bytes arrive on a byte-wide valid/ready stream and are held in a 16-entry receive queue. Software can read the oldest byte through two status/data words: one leaves the queue alone and the other also removes that byte. Writing the data-out word sends its low byte on an outgoing byte stream.

A raw interrupt word collects a receive level and two transmit event bits. A mask selects which raw bits reach the single level interrupt line, and an acknowledge word clears event bits. The acknowledge has a deliberate quirk. The first acknowledge after a transmit cannot clear bit 0. It only disarms the pending flag, so a second acknowledge is needed to clear that bit.

Bus protocol: the master raises `bus_req` with `bus_we`, `bus_addr` and `bus_wdata`, and holds them until it sees `bus_ack`. `bus_ack` is high for one cycle. On a read, `bus_rdata` is valid in the same cycle as `bus_ack`. The master drops `bus_req` in the cycle after `bus_ack`. Byte addresses are used, and only aligned word accesses take effect.

Top module: `uart_regif`

## Requirements
- R1: After reset the receive control word (0x08) reads 0x0001_0000 and `rx_ready` is 0. The raw interrupt word (0x34) and the plain storage words read 0, and `irq` is 0.
- R2: A status/data read (0x20 or 0x24) returns the oldest held byte in bits 7:0. Bit 16 is 1 exactly when the queue holds a byte. Bits 22 and 24 always read 1, and all other bits read 0.
- R3: A read at 0x24 leaves the queue unchanged. A read at 0x20 removes the oldest byte when the queue is non-empty, and removes nothing when it is empty.
- R4: The queue holds 16 bytes and returns them in arrival order. When it is full, `rx_ready` is 0 and a byte offered on `rx_valid` is not taken.
- R5: `rx_ready` equals bit 3 of the receive control word AND queue-not-full. Clearing that bit stops reception.
- R6: Raw interrupt bit 3 is 1 while the queue is non-empty and 0 once it drains.
- R7: A write to 0x1C produces one cycle of `tx_valid` with `tx_data` equal to bits 7:0 of the written word. The write also sets raw bits 0 and 1, and the word reads back from 0x1C.
- R8: While `tx_ready` is 0, a write to 0x1C is neither acknowledged nor sent. It completes once `tx_ready` returns to 1, and `tx_valid` is only raised in the cycle after `tx_ready` was 1.
- R9: A write to 0x30 clears the raw bits that are 1 in the written value. If a transmit is pending, bit 0 of the value is treated as 0 and the pending flag is cleared.
- R10: The masked word (0x38) reads raw AND mask (0x2C). `irq` is the OR of the masked bits and follows any change one clock later.
- R11: Other aligned word offsets below 0x3C (for example 0x10) read back what was written. Offset 0x3C reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus request, held until acknowledge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Receiver can take a byte |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Downstream can take a byte |
| irq | output | 1 | Level interrupt |

## Verification
A wrong queue pointer or count shows up at the next status/data read. It appears as a wrong byte, a wrong bit 16, or an `rx_ready` that does not fall at the sixteenth byte. A bad transmit-pending flag is exposed by the two-step acknowledge sequence: the raw word reads wrong right after the first acknowledge. Interrupt logic errors appear on `irq` one clock after the causing write or byte, and on the masked word read.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int unsigned NUM_WORDS   = 15;
  localparam int unsigned IDX_RXCTRL  = 2;
  localparam int unsigned IDX_DOUT    = 7;
  localparam int unsigned IDX_POP     = 8;
  localparam int unsigned IDX_PEEK    = 9;
  localparam int unsigned IDX_MASK    = 11;
  localparam int unsigned IDX_ACK     = 12;
  localparam int unsigned IDX_RAW     = 13;
  localparam int unsigned IDX_MASKED  = 14;

  localparam int unsigned RX_EN_BIT   = 3;
  localparam int unsigned RAW_RX_BIT  = 3;
  localparam logic [31:0] RXCTRL_INIT = 32'h0001_0000;

  function automatic logic [31:0] status_word(input logic [7:0] head, input logic avail);
    logic [31:0] w;
    w        = '0;
    w[7:0]   = head;
    w[16]    = avail;
    w[22]    = 1'b1;
    w[24]    = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic              do_push, do_pop;

  assign full    = (count == CMAX);
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_fire,
  input  logic         ack_we,
  input  logic [W-1:0] ack_val,
  input  logic         raw_we,
  input  logic [W-1:0] raw_wval,
  input  logic         rx_nonempty,
  input  logic [W-1:0] mask,
  output logic [W-1:0] raw_view,
  output logic [W-1:0] ack_eff,
  output logic         irq
);
  import uart_regif_pkg::*;

  localparam logic [W-1:0] RX_ONE  = W'(1) << RAW_RX_BIT;
  localparam logic [W-1:0] TX_BITS = W'(3);

  logic [W-1:0] raw_q;
  logic         pend_q;

  assign raw_view = raw_q | (rx_nonempty ? RX_ONE : '0);
  assign ack_eff  = pend_q ? (ack_val & ~W'(1)) : ack_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      pend_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (tx_fire) begin
        raw_q  <= raw_q | TX_BITS;
        pend_q <= 1'b1;
      end else if (ack_we) begin
        raw_q  <= raw_q & ~ack_eff;
        pend_q <= 1'b0;
      end else if (raw_we) begin
        raw_q  <= raw_wval & ~RX_ONE;
      end
      irq <= |(raw_view & mask);
    end
  end
endmodule

// File: rtl/uart_tx_port.sv
module uart_tx_port #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send,
  input  logic [DATA_W-1:0] send_data,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= send;
      if (send) tx_data <= send_data;
    end
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ack,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              irq
);
  import uart_regif_pkg::*;

  localparam int unsigned IW = ADDR_W - 2;
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [IW-1:0] A_RXCTRL = IW'(IDX_RXCTRL);
  localparam logic [IW-1:0] A_DOUT   = IW'(IDX_DOUT);
  localparam logic [IW-1:0] A_POP    = IW'(IDX_POP);
  localparam logic [IW-1:0] A_PEEK   = IW'(IDX_PEEK);
  localparam logic [IW-1:0] A_ACK    = IW'(IDX_ACK);
  localparam logic [IW-1:0] A_RAW    = IW'(IDX_RAW);
  localparam logic [IW-1:0] A_MASKED = IW'(IDX_MASKED);
  localparam logic [IW-1:0] A_LIMIT  = IW'(NUM_WORDS);

  logic [31:0]   regs_q [NUM_WORDS];
  logic [IW-1:0] idx;
  logic          hit, go, is_dout, stall, done, wr, rd;
  logic          tx_fire, fifo_pop, fifo_push;
  logic [7:0]    fifo_head;
  logic [CW-1:0] fifo_count;
  logic          fifo_full, fifo_empty, rx_en;
  logic [31:0]   raw_view, ack_eff, mask_q, rd_val;

  assign idx      = bus_addr[ADDR_W-1:2];
  assign hit      = (bus_addr[1:0] == 2'b00) && (idx < A_LIMIT);
  assign go       = bus_req && !bus_ack;
  assign is_dout  = hit && (idx == A_DOUT);
  assign stall    = bus_we && is_dout && !tx_ready;
  assign done     = go && !stall;
  assign wr       = done && bus_we && hit;
  assign rd       = done && !bus_we;
  assign tx_fire  = go && bus_we && is_dout && tx_ready;
  assign fifo_pop = rd && hit && (idx == A_POP);

  assign rx_en     = regs_q[IDX_RXCTRL][RX_EN_BIT];
  assign rx_ready  = rx_en && !fifo_full;
  assign fifo_push = rx_valid && rx_ready;
  assign mask_q    = regs_q[IDX_MASK];

  uart_rx_fifo #(.DATA_W(8), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst(rst),
    .push(fifo_push), .push_data(rx_data),
    .pop(fifo_pop), .head(fifo_head),
    .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  uart_irq_ctrl #(.W(32)) i_irq (
    .clk(clk), .rst(rst),
    .tx_fire(tx_fire),
    .ack_we(wr && (idx == A_ACK)), .ack_val(bus_wdata),
    .raw_we(wr && (idx == A_RAW)), .raw_wval(bus_wdata),
    .rx_nonempty(!fifo_empty), .mask(mask_q),
    .raw_view(raw_view), .ack_eff(ack_eff), .irq(irq)
  );

  uart_tx_port #(.DATA_W(8)) i_tx (
    .clk(clk), .rst(rst),
    .send(tx_fire), .send_data(bus_wdata[7:0]),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  always_comb begin
    rd_val = '0;
    if (hit) begin
      case (idx)
        A_POP, A_PEEK: rd_val = status_word(fifo_head, !fifo_empty);
        A_RAW:         rd_val = raw_view;
        A_MASKED:      rd_val = raw_view & mask_q;
        default:       rd_val = regs_q[idx];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NUM_WORDS); i++)
        regs_q[i] <= (i == int'(IDX_RXCTRL)) ? RXCTRL_INIT : '0;
    end else if (wr) begin
      regs_q[idx] <= (idx == A_ACK) ? ack_eff : bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= done;
      if (rd) bus_rdata <= rd_val;
    end
  end

  logic unused_rxctrl;
  assign unused_rxctrl = (A_RXCTRL == idx) && 1'b0;
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          bus_ack,
  input logic          rx_ready,
  input logic          rx_en,
  input logic [CW-1:0] count
);
  p_tx_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid);

  p_tx_needs_ready_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> $past(tx_ready));

  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_ready_gate_r5: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> (rx_en && (count < CW'(DEPTH))));

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count)) || (count == $past(count) + 1'b1) ||
    (count + 1'b1 == $past(count)));
endmodule

bind uart_regif uart_regif_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) i_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .bus_ack(bus_ack), .rx_ready(rx_ready), .rx_en(rx_en), .count(fifo_count)
);

// File: tb/test_uart_regif.sv
`timescale 1ns/1ps
module test_uart_regif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;
  logic        tx_ready = 1'b1;

  int checks = 0, fails = 0, tx_seen = 0;
  bit finished = 0;
  logic [7:0] exp_q [$];

  always #10 clk = ~clk;

  uart_regif i_uart_regif (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor side of the transmit scoreboard
  always @(negedge clk) begin
    if (!rst && tx_valid) begin
      tx_seen++;
      if (exp_q.size() == 0) chk("R7 unexpected byte", {24'h0, tx_data}, 32'hFFFF_FFFF);
      else chk("R7 tx byte", {24'h0, tx_data}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == 6'h1C) exp_q.push_back(d[7:0]);
    do @(negedge clk); while (!bus_ack);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    do @(negedge clk); while (!bus_ack);
    d = bus_rdata;
    bus_req = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_ready", {31'h0, rx_ready}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    bus_read(6'h08, r); chk("R1 rx ctrl", r, 32'h0001_0000);
    bus_read(6'h34, r); chk("R1 raw", r, 32'h0);
    bus_read(6'h00, r); chk("R1 storage", r, 32'h0);
    bus_read(6'h20, r); chk("R2 empty status", r & 32'hFFFF_FF00, 32'h0140_0000);

    // R5 enable receiver
    bus_write(6'h08, 32'h0001_0008);
    chk("R5 ready after enable", {31'h0, rx_ready}, 32'h1);

    // R2 R3 R6 peek and pop
    rx_send(8'hA5); rx_send(8'h3C);
    bus_read(6'h24, r); chk("R2 peek 1", r, 32'h0141_00A5);
    bus_read(6'h24, r); chk("R3 peek keeps", r, 32'h0141_00A5);
    bus_read(6'h34, r); chk("R6 raw bit3 set", r, 32'h8);
    bus_read(6'h20, r); chk("R3 pop 1", r, 32'h0141_00A5);
    bus_read(6'h24, r); chk("R3 after pop", r, 32'h0141_003C);
    bus_read(6'h20, r); chk("R3 pop 2", r, 32'h0141_003C);
    bus_read(6'h20, r); chk("R3 pop empty", r & 32'hFFFF_FF00, 32'h0140_0000);
    bus_read(6'h34, r); chk("R6 raw bit3 clear", r, 32'h0);

    // R10 receive interrupt
    bus_write(6'h2C, 32'h8);
    @(negedge clk); chk("R10 irq idle", {31'h0, irq}, 32'h0);
    rx_send(8'h11);
    @(negedge clk); chk("R10 irq on rx", {31'h0, irq}, 32'h1);
    bus_read(6'h38, r); chk("R10 masked", r, 32'h8);
    bus_read(6'h20, r); chk("R3 pop irq byte", r, 32'h0141_0011);
    @(negedge clk); chk("R10 irq drop", {31'h0, irq}, 32'h0);

    // R4 fill to full
    for (int i = 0; i < 16; i++) rx_send(8'(i * 7 + 1));
    @(negedge clk);
    chk("R4 ready low when full", {31'h0, rx_ready}, 32'h0);
    rx_valid = 1'b1; rx_data = 8'hEE;
    @(negedge clk); rx_valid = 1'b0;
    for (int i = 0; i < 16; i++) begin
      bus_read(6'h20, r); chk("R4 order", r, 32'h0141_0000 | 32'(8'(i * 7 + 1)));
    end
    bus_read(6'h24, r); chk("R4 dropped byte absent", r & 32'hFFFF_FF00, 32'h0140_0000);

    // R5 disable receiver
    bus_write(6'h08, 32'h0001_0000);
    chk("R5 ready after disable", {31'h0, rx_ready}, 32'h0);

    // R7 transmit
    bus_write(6'h2C, 32'h0);
    bus_write(6'h1C, 32'h1234_5678);
    bus_read(6'h34, r); chk("R7 raw tx bits", r, 32'h3);
    bus_read(6'h1C, r); chk("R7 dout readback", r, 32'h1234_5678);

    // R9 acknowledge quirk
    bus_write(6'h30, 32'h3);
    bus_read(6'h34, r); chk("R9 first ack keeps bit0", r, 32'h1);
    bus_write(6'h30, 32'h1);
    bus_read(6'h34, r); chk("R9 second ack clears", r, 32'h0);
    bus_write(6'h1C, 32'h41);
    bus_write(6'h30, 32'h0);
    bus_read(6'h34, r); chk("R9 zero ack disarms", r, 32'h3);
    bus_write(6'h30, 32'h1);
    bus_read(6'h34, r); chk("R9 bit0 ack unpended", r, 32'h2);

    // R8 stalled transmit
    begin
      bit wr_done = 0;
      int seen0;
      tx_ready = 1'b0;
      seen0 = tx_seen;
      fork
        begin bus_write(6'h1C, 32'h9C); wr_done = 1; end
        begin
          repeat (6) @(negedge clk);
          chk("R8 no ack while stalled", {31'h0, wr_done}, 32'h0);
          chk("R8 no byte while stalled", 32'(tx_seen), 32'(seen0));
          tx_ready = 1'b1;
        end
      join
      @(negedge clk);
      chk("R8 byte after release", 32'(tx_seen), 32'(seen0 + 1));
    end

    // R10 transmit interrupt
    bus_write(6'h2C, 32'h3);
    @(negedge clk); chk("R10 irq tx", {31'h0, irq}, 32'h1);
    bus_read(6'h38, r); chk("R10 masked tx", r, 32'h3);
    bus_write(6'h30, 32'h3);
    bus_write(6'h30, 32'h1);
    @(negedge clk); chk("R10 irq cleared", {31'h0, irq}, 32'h0);

    // R11 storage and out-of-range
    bus_write(6'h10, 32'hDEAD_BEEF);
    bus_read(6'h10, r); chk("R11 storage", r, 32'hDEAD_BEEF);
    bus_write(6'h3C, 32'hFFFF_FFFF);
    bus_read(6'h3C, r); chk("R11 beyond range", r, 32'h0);

    repeat (3) @(negedge clk);
    chk("R7 scoreboard drained", 32'(exp_q.size()), 32'h0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule